// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block manages 32 general-purpose pins through a small word-addressed register file. Software picks, for each pin, whether it is driven or sensed and what level it drives. It can also read back the pad level after a two-flop synchroniser.

Every pin can flag an event. The event is either a level, high or low, or an edge, rising or falling, chosen by a 2-bit code per pin. A separate per-pin bit turns the pin into a both-edges detector. Flagged events are held in a sticky status register, which software clears by writing ones. A mask register selects which held events may reach the processor. The masked events are merged into two interrupt lines, one for pins 0 to 15 and one for pins 16 to 31.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: `pad_oe` equals the direction register at word address 1 and `pad_out` equals the data register at word address 0. Both read back as written and change on the clock edge that takes the write.
- R2: The pad status register at word address 2 returns `pad_in` delayed by two clock edges. It still shows the old value after one edge.
- R3: The config word at word address 3 holds the 2-bit code for pin p (p < 16) at bits [2p+1:2p]. The word at address 4 holds the code for pin p (p >= 16) at bits [2(p-16)+1:2(p-16)]. Code 0 sets the status bit every cycle the synchronised pin is low, and code 1 every cycle it is high.
- R4: Code 2 sets status on a low-to-high change and code 3 on a high-to-low change. The status bit becomes visible on the third clock edge after the pad changes.
- R5: When a pin's bit in the any-edge register at word address 7 is 1, either edge on that pin sets its status, whatever its 2-bit code.
- R6: A write to the status register at word address 6 clears every bit written as 1 and leaves bits written as 0 unchanged. All ones clears every pending bit that has no new event.
- R7: When an event and a clear of the same bit fall on one edge, the bit stays set. A pin whose level condition remains true is therefore set again right after a clear.
- R8: The mask register sits at word address 5. A pin contributes to an interrupt line only while both its status bit and its mask bit are 1.
- R9: `irq_lo` is the OR of the masked pending bits of pins 0 to 15, and `irq_hi` the same for pins 16 to 31.
- R10: Reset clears every register, so all pins are inputs, nothing is masked in and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address of the register (byte offset divided by four) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output levels to the pads |
| pad_oe | output | 32 | Output enables, 1 = driven |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
A status write that clears a bit can land on the same edge as a new event on that pin, and the new event must win. The bench provokes this in two ways. It changes a pad exactly two edges before a clear write, so the edge detection and the clear meet on the third edge. It also holds a level trigger true while clearing that pin. In both cases it judges by reading status: the raced pin must read set. A second pin cleared by the same write, which has no new event, must read clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPINS  = 32;
    localparam int HALF   = NPINS / 2;
    localparam int ADDR_W = 3;
    localparam int CODE_W = 2;

    typedef logic [NPINS-1:0] pinvec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_PAD  = 3'd2,
        REG_CFGL = 3'd3,
        REG_CFGH = 3'd4,
        REG_MASK = 3'd5,
        REG_STAT = 3'd6,
        REG_ESEL = 3'd7
    } reg_sel_t;

    typedef enum logic [CODE_W-1:0] {
        TRG_LOW  = 2'd0,
        TRG_HIGH = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_t;

    typedef struct packed {
        logic [CODE_W*NPINS-1:0] cfg;
        pinvec_t                 data;
        pinvec_t                 dir;
        pinvec_t                 mask;
        pinvec_t                 esel;
    } ctrl_t;

    function automatic logic pin_hit(input trig_t code, input logic anyedge,
                                     input logic cur, input logic prev);
        logic h;
        if (anyedge) begin
            h = cur ^ prev;
        end else begin
            case (code)
                TRG_LOW:  h = !cur;
                TRG_HIGH: h = cur;
                TRG_RISE: h = cur & !prev;
                default:  h = !cur & prev;
            endcase
        end
        return h;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur_o  = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_irq_pkg::*;
(
    input  logic [CODE_W*NPINS-1:0] cfg_i,
    input  pinvec_t                 esel_i,
    input  pinvec_t                 cur_i,
    input  pinvec_t                 prev_i,
    output pinvec_t                 hit_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit_o[i] = pin_hit(trig_t'(cfg_i[CODE_W*i +: CODE_W]),
                                  esel_i[i], cur_i[i], prev_i[i]);
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  pinvec_t           wdata,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_t'(addr))
                REG_DATA: ctrl_q.data <= wdata;
                REG_DIR:  ctrl_q.dir  <= wdata;
                REG_CFGL: ctrl_q.cfg[NPINS-1:0] <= wdata;
                REG_CFGH: ctrl_q.cfg[2*NPINS-1:NPINS] <= wdata;
                REG_MASK: ctrl_q.mask <= wdata;
                REG_ESEL: ctrl_q.esel <= wdata;
                default:  ;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/gpio_status.sv
module gpio_status
    import gpio_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t set_i,
    input  pinvec_t clr_i,
    output pinvec_t status_o
);
    pinvec_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= (st_q & ~clr_i) | set_i;
    end

    assign status_o = st_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    ctrl_t   ctrl;
    pinvec_t cur, prev, hit, clr, status_q, pend;

    gpio_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .ctrl_o(ctrl)
    );

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .async_i(pad_in), .cur_o(cur), .prev_o(prev)
    );

    gpio_detect u_det (
        .cfg_i(ctrl.cfg), .esel_i(ctrl.esel), .cur_i(cur), .prev_i(prev),
        .hit_o(hit)
    );

    assign clr = (wr_en && reg_sel_t'(addr) == REG_STAT) ? wdata : '0;

    gpio_status u_stat (
        .clk(clk), .rst(rst), .set_i(hit), .clr_i(clr), .status_o(status_q)
    );

    always_comb begin
        case (reg_sel_t'(addr))
            REG_DATA: rdata = ctrl.data;
            REG_DIR:  rdata = ctrl.dir;
            REG_PAD:  rdata = cur;
            REG_CFGL: rdata = ctrl.cfg[NPINS-1:0];
            REG_CFGH: rdata = ctrl.cfg[2*NPINS-1:NPINS];
            REG_MASK: rdata = ctrl.mask;
            REG_STAT: rdata = status_q;
            default:  rdata = ctrl.esel;
        endcase
    end

    assign pend    = status_q & ctrl.mask;
    assign irq_lo  = |pend[HALF-1:0];
    assign irq_hi  = |pend[NPINS-1:HALF];
    assign pad_out = ctrl.data;
    assign pad_oe  = ctrl.dir;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input pinvec_t           wdata,
    input pinvec_t           hit,
    input pinvec_t           clr,
    input pinvec_t           status_q,
    input pinvec_t           mask,
    input pinvec_t           pad_oe,
    input logic              irq_lo,
    input logic              irq_hi
);
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status_q & $past(hit)) == $past(hit)));  // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~hit)) |=> ((status_q & $past(clr & ~hit)) == '0));  // R6
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (|(~clr & ~hit)) |=> ((status_q & $past(~clr & ~hit)) == ($past(status_q) & $past(~clr & ~hit))));  // R6
    AST_LO_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask[HALF-1:0] == '0) |-> !irq_lo);  // R8
    AST_HI_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask[NPINS-1:HALF] == '0) |-> !irq_hi);  // R9
    AST_LO_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (|status_q[HALF-1:0]));  // R8
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_DIR) |=> (pad_oe == $past(wdata)));  // R1
endmodule

bind gpio_irq_ctrl gpio_irq_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(hit), .clr(clr), .status_q(status_q), .mask(ctrl.mask),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int fails  = 0;

    gpio_irq_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [31:0] cl, ch, es, pre, post, exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'hAAAAAAAA, 32'hAAAAAAAA, 32'h0, 32'h0,        32'h000000F1, 32'h000000F1},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hFFFF0000, 32'h0F0F0000, 32'hF0F00000},
        '{32'h55555555, 32'h55555555, 32'h0, 32'h0,        32'h80000001, 32'h80000001},
        '{32'h00000000, 32'h00000000, 32'h0, 32'hFFFFFFFF, 32'hFFFF00FF, 32'h0000FF00},
        '{32'hAAAAAAAA, 32'hAAAAAAAA, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000, 32'hFFFFFFFF},
        '{32'hAAAAAAA7, 32'hAAAAAAAB, 32'h0, 32'h00010001, 32'h00000002, 32'h00010003}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R10: reset state
        idle(3);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R10 reg reset", v, 32'h0);
        end
        check("R10 pad_oe reset", pad_oe, 32'h0);
        check("R10 irq reset", {30'h0, irq_hi, irq_lo}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // vector table: R3 R4 R5 R6
        foreach (VECS[n]) begin
            wr(3'd3, VECS[n].cl);
            wr(3'd4, VECS[n].ch);
            wr(3'd7, VECS[n].es);
            pad_in = VECS[n].pre;
            idle(4);
            wr(3'd6, 32'hFFFFFFFF);
            rd(3'd6, v);
            check("R6 all-ones clear", v, 32'h0);
            pad_in = VECS[n].post;
            idle(4);
            rd(3'd6, v);
            check("R3/R4/R5 vector status", v, VECS[n].exp);
            check("R8 masked irq quiet", {30'h0, irq_hi, irq_lo}, 32'h0);
        end

        // R1 direction and data
        wr(3'd1, 32'h0000FFFF);
        wr(3'd0, 32'h12345678);
        check("R1 pad_oe", pad_oe, 32'h0000FFFF);
        check("R1 pad_out", pad_out, 32'h12345678);
        rd(3'd1, v); check("R1 dir readback", v, 32'h0000FFFF);
        rd(3'd0, v); check("R1 data readback", v, 32'h12345678);

        // clean setup: rising everywhere
        wr(3'd3, 32'hAAAAAAAA);
        wr(3'd4, 32'hAAAAAAAA);
        wr(3'd7, 32'h0);
        pad_in = 32'h0;
        idle(4);
        wr(3'd6, 32'hFFFFFFFF);

        // R2 and R4 timing
        pad_in = 32'h20;
        @(negedge clk);
        rd(3'd2, v); check("R2 pad after one edge", v, 32'h0);
        @(negedge clk);
        rd(3'd2, v); check("R2 pad after two edges", v, 32'h20);
        rd(3'd6, v); check("R4 status before third edge", v, 32'h0);
        @(negedge clk);
        rd(3'd6, v); check("R4 status on third edge", v, 32'h20);

        // R6 write zero keeps, write one clears
        wr(3'd6, 32'h0);
        rd(3'd6, v); check("R6 write zero no effect", v, 32'h20);
        wr(3'd6, 32'h20);
        rd(3'd6, v); check("R6 write one clears", v, 32'h0);
        pad_in = 32'h60;
        idle(4);
        rd(3'd6, v); check("R4 pin6 rise", v, 32'h40);

        // R7 edge event and clear on the same edge
        pad_in = 32'h260;
        @(negedge clk);
        @(negedge clk);
        wr(3'd6, 32'h240);
        rd(3'd6, v); check("R7 set wins over clear", v, 32'h200);

        // R7 level persistence: pin5 high level
        wr(3'd3, 32'hAAAAA6AA);
        idle(1);
        wr(3'd6, 32'h20);
        rd(3'd6, v); check("R7 level re-sets", v, 32'h220);

        // R8 R9 masking and line split
        pad_in = 32'h00100260;
        idle(4);
        rd(3'd6, v); check("R4 pin20 rise", v, 32'h00100220);
        check("R8 no mask no irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        wr(3'd5, 32'h00000200);
        check("R9 low line only", {30'h0, irq_hi, irq_lo}, 32'h1);
        wr(3'd5, 32'h00100000);
        check("R9 high line only", {30'h0, irq_hi, irq_lo}, 32'h2);
        wr(3'd5, 32'hFFFFFFFF);
        check("R9 both lines", {30'h0, irq_hi, irq_lo}, 32'h3);
        wr(3'd6, 32'hFFFFFFFF);
        rd(3'd6, v); check("R6 all-ones clear keeps level pin", v, 32'h20);
        check("R8 irq after clear", {30'h0, irq_hi, irq_lo}, 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule